// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block is a small bank of byte-wide control registers that sits on a simple synchronous bus inside a workstation I/O controller. It holds a configuration register, two auxiliary registers, a diagnostic register, a modem control register, a system control register and a power management location. Software uses it to enable and acknowledge a power-fail interrupt, to request a machine shutdown and to request a system reset. The shutdown and reset requests leave the block as one-cycle pulses. The logic that sequences power-down and reset lies outside the block.

A power-fail input is edge-sampled into a sticky flag that can raise a level interrupt. The flag is built as a two-state machine. `PF_CLEAR` moves to `PF_RAISED` when the input changes, the input is now high and the configuration enable is set. `PF_RAISED` returns to `PF_CLEAR` on any of three events: an input change that leaves the enable or the input low, a write-one-to-clear on the second auxiliary register, or a soft block reset. With none of these events the state holds.

There are two resets. The asynchronous power-up reset clears everything. The synchronous soft block reset clears only the configuration, first auxiliary, second auxiliary and modem control registers.

Top module: `auxsys_ctrl`

## Requirements
- R1: Registers are selected by address bits 27:16 only, and bits 15:0 are ignored. The offsets are 0x1800000 for configuration, 0x1900000 for the first auxiliary register, 0x1A00000 for diagnostic and 0x1B00000 for modem control. Each of these four stores the whole byte written on data bits 7:0 and reads it back unchanged.
- R2: A write to the power management offset 0xA000000 changes nothing. A read from that offset, or from any address that matches no register, returns zero.
- R3: `irq` is high exactly when the power-fail flag is set and configuration bit 3 (the enable) is set. It follows a configuration write on the cycle after that write.
- R4: A power-fail input change is a cycle in which `pwr_fail` differs from its value on the previous clock. On such a change the flag becomes `pwr_fail` AND configuration bit 3, using the enable value held before that cycle's write.
- R5: A write to the second auxiliary register (offset 0x1910000) keeps only data bits 1:0. Written bit 1 clears the flag. Bit 1 itself is never stored. Bit 0 is stored. Reading the register returns the flag in bit 2, the stored bit in bit 0 and zero in every other bit.
- R6: A write to the second auxiliary register with data bit 0 set makes `shutdown_req` high for exactly the one cycle after that write.
- R7: A write to the system control register (offset 0x1F00000) with bit 0 set loads the register with 0x02 and makes `sysreset_req` high for the one cycle after that write. A write with bit 0 clear leaves the register unchanged.
- R8: In a cycle where `soft_rst` is high, all bus writes are ignored. On that clock the configuration, first auxiliary, second auxiliary (including the flag) and modem control registers clear to zero, while diagnostic and system control keep their values.
- R9: `bus_rdata` takes the addressed value one cycle after a read strobe, using register contents from before any write in the same cycle. Without a read strobe it holds its previous value.
- R10: `bus_rdata` bits above bit 7 always read zero.
- R11: While `rst_n` is low, every register clears to zero, including diagnostic and system control, and `irq`, both pulses and `bus_rdata` are low.
- R12: When a power-fail input change and a flag-clearing write to the second auxiliary register fall in the same cycle, the input change decides the flag.
- R13: With no input change, no clearing write and no soft reset, the flag holds. A configuration write alone neither sets nor clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| soft_rst | input | 1 | Synchronous soft block reset |
| bus_addr | input | 28 | Byte address |
| bus_wdata | input | 32 | Write data; bits 7:0 are used |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pwr_fail | input | 1 | Power-fail indication |
| irq | output | 1 | Level power-fail interrupt |
| shutdown_req | output | 1 | One-cycle shutdown request |
| sysreset_req | output | 1 | One-cycle system reset request |

## Verification
The hardest case to reach is a power-fail input change that lands in the same cycle as a flag-clearing write or a soft reset, with the enable being rewritten at about the same time. The flag can only be seen through a read of the second auxiliary register or through `irq`. Directed sequences line up an input toggle with a clearing write, both with the enable set and with it cleared, and re-enable the enable while the flag is set. Random traffic then toggles the input rarely, over addresses that carry random low bits, with reads, writes and soft resets mixed in.

// File: rtl/auxsys_pkg.sv
package auxsys_pkg;

    localparam int NUM_SEL = 7;

    localparam int SEL_CFG    = 0;
    localparam int SEL_AUX1   = 1;
    localparam int SEL_AUX2   = 2;
    localparam int SEL_DIAG   = 3;
    localparam int SEL_MODEM  = 4;
    localparam int SEL_SYSCTL = 5;
    localparam int SEL_PWRMGT = 6;

    localparam logic [27:0] DEC_MASK = 28'hFFF_0000;

    localparam int CFG_EN_BIT  = 3;
    localparam int AUX2_PF_BIT = 2;
    localparam int AUX2_CLR_BIT = 1;
    localparam int AUX2_OFF_BIT = 0;
    localparam int SYS_RST_BIT = 0;
    localparam logic [7:0] SYS_RST_VALUE = 8'h02;

    typedef enum logic {
        PF_CLEAR  = 1'b0,
        PF_RAISED = 1'b1
    } pf_state_e;

    function automatic logic [27:0] sel_offset(input int idx);
        case (idx)
            SEL_CFG:    return 28'h180_0000;
            SEL_AUX1:   return 28'h190_0000;
            SEL_AUX2:   return 28'h191_0000;
            SEL_DIAG:   return 28'h1A0_0000;
            SEL_MODEM:  return 28'h1B0_0000;
            SEL_SYSCTL: return 28'h1F0_0000;
            default:    return 28'hA00_0000;
        endcase
    endfunction

endpackage

// File: rtl/auxsys_decode.sv
module auxsys_decode
    import auxsys_pkg::*;
#(
    parameter int ADDR_W = 28
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_SEL-1:0] hit
);

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        assign hit[i] = ((addr & DEC_MASK[ADDR_W-1:0]) == sel_offset(i)[ADDR_W-1:0]);
    end

endmodule

// File: rtl/auxsys_pfail.sv
module auxsys_pfail
    import auxsys_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic pwr_fail,
    input  logic cfg_en,
    input  logic clr_wr,
    output logic pf_edge,
    output logic pf_flag,
    output logic irq
);

    pf_state_e state_q, state_d;
    logic      pf_q;

    assign pf_edge = (pwr_fail != pf_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PF_CLEAR;
            pf_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            pf_q    <= pwr_fail;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PF_CLEAR: begin
                if (!soft_rst && pf_edge && pwr_fail && cfg_en) begin
                    state_d = PF_RAISED;
                end
            end
            PF_RAISED: begin
                if (soft_rst) begin
                    state_d = PF_CLEAR;
                end else if (pf_edge) begin
                    state_d = (pwr_fail && cfg_en) ? PF_RAISED : PF_CLEAR;
                end else if (clr_wr) begin
                    state_d = PF_CLEAR;
                end
            end
            default: state_d = PF_CLEAR;
        endcase
    end

    always_comb begin
        pf_flag = (state_q == PF_RAISED);
        irq     = pf_flag && cfg_en;
    end

endmodule

// File: rtl/auxsys_regs.sv
module auxsys_regs
    import auxsys_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic [NUM_SEL-1:0] hit,
    input  logic               we,
    input  logic               re,
    input  logic [REG_W-1:0]   wbyte,
    input  logic               pf_flag,
    output logic [REG_W-1:0]   rbyte,
    output logic               cfg_en,
    output logic               clr_wr,
    output logic               shutdown_req,
    output logic               sysreset_req,
    output logic [REG_W-1:0]   cfg_q,
    output logic [REG_W-1:0]   diag_q,
    output logic [REG_W-1:0]   sysctl_q
);

    logic [REG_W-1:0] aux1_q, modem_q, rd_mux;
    logic             aux2_off_q;

    assign cfg_en = cfg_q[CFG_EN_BIT];
    assign clr_wr = we && hit[SEL_AUX2] && wbyte[AUX2_CLR_BIT];

    always_comb begin
        rd_mux = '0;
        if (hit[SEL_CFG])    rd_mux = cfg_q;
        if (hit[SEL_AUX1])   rd_mux = aux1_q;
        if (hit[SEL_AUX2]) begin
            rd_mux[AUX2_PF_BIT]  = pf_flag;
            rd_mux[AUX2_OFF_BIT] = aux2_off_q;
        end
        if (hit[SEL_DIAG])   rd_mux = diag_q;
        if (hit[SEL_MODEM])  rd_mux = modem_q;
        if (hit[SEL_SYSCTL]) rd_mux = sysctl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q        <= '0;
            aux1_q       <= '0;
            aux2_off_q   <= 1'b0;
            diag_q       <= '0;
            modem_q      <= '0;
            sysctl_q     <= '0;
            rbyte        <= '0;
            shutdown_req <= 1'b0;
            sysreset_req <= 1'b0;
        end else begin
            shutdown_req <= 1'b0;
            sysreset_req <= 1'b0;
            if (re) begin
                rbyte <= rd_mux;
            end
            if (soft_rst) begin
                cfg_q      <= '0;
                aux1_q     <= '0;
                aux2_off_q <= 1'b0;
                modem_q    <= '0;
            end else if (we) begin
                if (hit[SEL_CFG])   cfg_q   <= wbyte;
                if (hit[SEL_AUX1])  aux1_q  <= wbyte;
                if (hit[SEL_DIAG])  diag_q  <= wbyte;
                if (hit[SEL_MODEM]) modem_q <= wbyte;
                if (hit[SEL_AUX2]) begin
                    aux2_off_q   <= wbyte[AUX2_OFF_BIT];
                    shutdown_req <= wbyte[AUX2_OFF_BIT];
                end
                if (hit[SEL_SYSCTL] && wbyte[SYS_RST_BIT]) begin
                    sysctl_q     <= SYS_RST_VALUE[REG_W-1:0];
                    sysreset_req <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/auxsys_ctrl.sv
module auxsys_ctrl
    import auxsys_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 32,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pwr_fail,
    output logic              irq,
    output logic              shutdown_req,
    output logic              sysreset_req
);

    localparam int PAD_W = DATA_W - REG_W;

    logic [NUM_SEL-1:0] hit;
    logic [REG_W-1:0]   rbyte, cfg_q, diag_q, sysctl_q;
    logic               cfg_en, clr_wr, pf_edge, pf_flag;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:REG_W];
    assign bus_rdata       = {{PAD_W{1'b0}}, rbyte};

    auxsys_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .hit  (hit)
    );

    auxsys_pfail u_pfail (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .pwr_fail (pwr_fail),
        .cfg_en   (cfg_en),
        .clr_wr   (clr_wr),
        .pf_edge  (pf_edge),
        .pf_flag  (pf_flag),
        .irq      (irq)
    );

    auxsys_regs #(.REG_W(REG_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .hit          (hit),
        .we           (bus_we),
        .re           (bus_re),
        .wbyte        (bus_wdata[REG_W-1:0]),
        .pf_flag      (pf_flag),
        .rbyte        (rbyte),
        .cfg_en       (cfg_en),
        .clr_wr       (clr_wr),
        .shutdown_req (shutdown_req),
        .sysreset_req (sysreset_req),
        .cfg_q        (cfg_q),
        .diag_q       (diag_q),
        .sysctl_q     (sysctl_q)
    );

endmodule

// File: rtl/auxsys_ctrl_chk.sv
module auxsys_ctrl_chk #(
    parameter int DATA_W = 32,
    parameter int REG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              bus_we,
    input logic              bus_re,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              pwr_fail,
    input logic              irq,
    input logic              shutdown_req,
    input logic              sysreset_req,
    input logic              pf_edge,
    input logic              pf_flag,
    input logic              clr_wr,
    input logic [REG_W-1:0]  cfg_q,
    input logic [REG_W-1:0]  diag_q,
    input logic [REG_W-1:0]  sysctl_q
);

    assert_irq_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cfg_q[3]);

    assert_irq_follows_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_flag && cfg_q[3]) |-> irq);

    assert_flag_on_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pf_edge && !soft_rst) |-> (pf_flag == $past(pwr_fail && cfg_q[3])));

    assert_clear_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_wr && !pf_edge) |-> !pf_flag);

    assert_shutdown_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(bus_we && bus_wdata[0] && !soft_rst));

    assert_sysreset_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sysreset_req |-> (sysctl_q == 8'h02));

    assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> (cfg_q == '0 && !pf_flag && diag_q == $past(diag_q)
                             && sysctl_q == $past(sysctl_q)));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_re) |-> $stable(bus_rdata));

    assert_rdata_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:REG_W] == '0);

    assert_change_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pf_edge && clr_wr && pwr_fail && cfg_q[3] && !soft_rst) |-> pf_flag);

    assert_flag_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!pf_edge && !clr_wr && !soft_rst) |-> $stable(pf_flag));

endmodule

bind auxsys_ctrl auxsys_ctrl_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .bus_we       (bus_we),
    .bus_re       (bus_re),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pwr_fail     (pwr_fail),
    .irq          (irq),
    .shutdown_req (shutdown_req),
    .sysreset_req (sysreset_req),
    .pf_edge      (pf_edge),
    .pf_flag      (pf_flag),
    .clr_wr       (clr_wr),
    .cfg_q        (cfg_q),
    .diag_q       (diag_q),
    .sysctl_q     (sysctl_q)
);

// File: tb/auxsys_ctrl_bench.sv
module auxsys_ctrl_bench;

    localparam logic [27:0] A_CFG  = 28'h180_0000;
    localparam logic [27:0] A_AUX1 = 28'h190_0000;
    localparam logic [27:0] A_AUX2 = 28'h191_0000;
    localparam logic [27:0] A_DIAG = 28'h1A0_0000;
    localparam logic [27:0] A_MDM  = 28'h1B0_0000;
    localparam logic [27:0] A_SYS  = 28'h1F0_0000;
    localparam logic [27:0] A_PWR  = 28'hA00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [27:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        pwr_fail = 1'b0;
    logic        irq, shutdown_req, sysreset_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0] m_cfg, m_aux1, m_diag, m_mdm, m_sys, m_rd;
    logic       m_off, m_flag, m_pfq;

    always #10 clk = ~clk;

    auxsys_ctrl u_auxsys_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .pwr_fail(pwr_fail), .irq(irq),
        .shutdown_req(shutdown_req), .sysreset_req(sysreset_req)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [27:0] a);
        case (a & 28'hFFF_0000)
            A_CFG:  return m_cfg;
            A_AUX1: return m_aux1;
            A_AUX2: return {5'b0, m_flag, 1'b0, m_off};
            A_DIAG: return m_diag;
            A_MDM:  return m_mdm;
            A_SYS:  return m_sys;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string read_tag(input logic [27:0] a);
        case (a & 28'hFFF_0000)
            A_CFG, A_AUX1, A_DIAG, A_MDM: return "R1";
            A_AUX2: return "R5";
            A_SYS:  return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic model_reset();
        m_cfg = 0; m_aux1 = 0; m_diag = 0; m_mdm = 0; m_sys = 0; m_rd = 0;
        m_off = 0; m_flag = 0; m_pfq = 0;
    endtask

    // One bus cycle: drive at negedge, update model, check after the edge.
    task automatic step(input bit we, input bit re, input logic [27:0] a,
                        input logic [31:0] wd, input bit pf, input bit srst);
        logic [7:0] wb, prev_rd;
        bit exp_sd, exp_sr, edge_ev, old_en;
        logic [27:0] dec;
        @(negedge clk);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd;
        pwr_fail = pf; soft_rst = srst;
        wb = wd[7:0];
        dec = a & 28'hFFF_0000;
        prev_rd = m_rd;
        if (re) m_rd = model_read(a);
        exp_sd = 0; exp_sr = 0;
        edge_ev = (pf != m_pfq);
        old_en = m_cfg[3];
        m_pfq = pf;
        if (srst) begin
            m_cfg = 0; m_aux1 = 0; m_off = 0; m_mdm = 0; m_flag = 0;
        end else begin
            if (edge_ev) m_flag = pf & old_en;
            else if (we && dec == A_AUX2 && wb[1]) m_flag = 0;
            if (we) begin
                case (dec)
                    A_CFG:  m_cfg = wb;
                    A_AUX1: m_aux1 = wb;
                    A_DIAG: m_diag = wb;
                    A_MDM:  m_mdm = wb;
                    A_AUX2: begin m_off = wb[0]; exp_sd = wb[0]; end
                    A_SYS:  if (wb[0]) begin m_sys = 8'h02; exp_sr = 1; end
                    default: ;
                endcase
            end
        end
        @(posedge clk);
        #2;
        if (re) begin
            check(bus_rdata[7:0] == m_rd, read_tag(a), bus_rdata, {24'h0, m_rd});
            check(bus_rdata[31:8] == 0, "R10", bus_rdata, {24'h0, m_rd});
        end else begin
            check(bus_rdata == {24'h0, prev_rd}, "R9", bus_rdata, {24'h0, prev_rd});
        end
        check(irq == (m_flag & m_cfg[3]), "R3", irq, m_flag & m_cfg[3]);
        check(shutdown_req == exp_sd, "R6", shutdown_req, exp_sd);
        check(sysreset_req == exp_sr, "R7", sysreset_req, exp_sr);
    endtask

    task automatic rd(input logic [27:0] a);
        step(0, 1, a, 0, pwr_fail, 0);
    endtask

    task automatic wr(input logic [27:0] a, input logic [31:0] d);
        step(1, 0, a, d, pwr_fail, 0);
    endtask

    function automatic logic [27:0] pick_addr(input int k);
        logic [27:0] lo;
        lo = 28'($urandom & 32'hFFFF);
        case (k)
            0: return A_CFG | lo;
            1: return A_AUX1 | lo;
            2: return A_AUX2 | lo;
            3: return A_DIAG | lo;
            4: return A_MDM | lo;
            5: return A_SYS | lo;
            6: return A_PWR | lo;
            default: return 28'($urandom);
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        // R11: outputs low during power-up reset
        check(bus_rdata == 0 && !irq && !shutdown_req && !sysreset_req, "R11",
              {bus_rdata[28:0], irq, shutdown_req, sysreset_req}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: every register reads zero after power-up
        for (int k = 0; k < 7; k++) rd(pick_addr(k));

        // R1: full-byte storage with low address bits ignored
        wr(A_CFG | 28'h1234, 32'hFFFF_FF5A);
        wr(A_AUX1 | 28'hFFFF, 32'h0000_00C3);
        wr(A_DIAG, 32'h0000_0077);
        wr(A_MDM | 28'h0001, 32'h0000_00E1);
        rd(A_CFG); rd(A_AUX1 | 28'h8000); rd(A_DIAG); rd(A_MDM);
        // R2: power management write ignored, reads zero; undecoded reads zero
        wr(A_PWR, 32'hFF);
        rd(A_PWR); rd(28'h190_0000 + 28'h2_0000); rd(A_CFG);

        // R7: system control bit0 clear leaves it, bit0 set loads 0x02
        wr(A_SYS, 32'hFE); rd(A_SYS);
        wr(A_SYS, 32'h01); rd(A_SYS);

        // R4/R3: enable then power fail -> flag and irq
        wr(A_CFG, 32'h08);
        step(0, 1, A_AUX2, 0, 1, 0);
        rd(A_AUX2);
        // R13: config write with enable cleared keeps flag, irq drops; re-enable raises irq
        wr(A_CFG, 32'h00); rd(A_AUX2);
        wr(A_CFG, 32'h08); rd(A_AUX2);
        // R5: write bit1 clears flag, bit1 not stored; bit0 kept with shutdown pulse (R6)
        wr(A_AUX2, 32'h03); rd(A_AUX2);
        // R13: input stays high, flag stays clear
        rd(A_AUX2);
        // R12: input change and clearing write in same cycle: change decides
        step(1, 0, A_AUX2, 32'h02, 0, 0);
        step(1, 0, A_AUX2, 32'h02, 1, 0);
        rd(A_AUX2);
        // R4: change with enable clear clears flag
        wr(A_CFG, 32'h00);
        step(0, 1, A_AUX2, 0, 0, 0);
        rd(A_AUX2);
        // R4: rising input with enable clear does not set
        step(0, 1, A_AUX2, 0, 1, 0); rd(A_AUX2);

        // R8: soft reset clears some, keeps diagnostic and system control
        wr(A_CFG, 32'h08);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        wr(A_AUX1, 32'h99); wr(A_MDM, 32'h44); wr(A_DIAG, 32'h3C);
        step(1, 0, A_DIAG, 32'h11, pwr_fail, 1);
        for (int k = 0; k < 6; k++) rd(pick_addr(k));

        // Random mixed traffic
        for (int n = 0; n < 3000; n++) begin
            int k;
            bit pf;
            k = int'($urandom_range(0, 7));
            pf = ($urandom_range(0, 15) == 0) ? ~pwr_fail : pwr_fail;
            step(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), pick_addr(k),
                 $urandom, pf, ($urandom_range(0, 40) == 0));
        end

        // R11: power-up reset clears diagnostic and system control too
        wr(A_DIAG, 32'h5A); wr(A_SYS, 32'h01);
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        pwr_fail = 1'b0;
        bus_we = 0; bus_re = 0; soft_rst = 0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(A_DIAG); rd(A_SYS); rd(A_CFG);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule